// File: doc/BRIEF.md
# Parallel EEPROM Page Programmer

This block is a bus master that programs one page of a byte-wide parallel EEPROM. A host fills a small local buffer and pulses a start request. The request carries a page number, a starting offset inside the page, a byte count and a phase length in clock cycles. The engine first sends the three-write unlock command. It then writes the buffered bytes back to back into the chosen page and waits for the device's internal programming cycle to end. Once the end is seen, it releases the bus.

Completion is detected by repeated read cycles of the last address written. In the default mode the engine stops when the returned bit 7 equals the true bit 7 of the last byte written. In the alternative mode it stops when bit 6 returns the same value on two reads in a row. If completion is not seen within a fixed cycle budget, the engine reports a timeout. A request with a bad byte count is refused without touching the bus.

The memory-side pins are active-low chip, output and write strobes, an address bus and a split data bus (value out, drive enable, value in) that forms the tri-state pad outside the block. Each phase of a bus cycle lasts the programmed number of clocks, so the user sets that number to meet the device's nanosecond limits at the clock in use.

Top module: `eeprog_top`

## Requirements
- R1: After reset `ceN`, `oeN` and `weN` are 1, `memDataOe` is 0, and `busy`, `done`, `timeoutErr` and `rejectErr` are 0.
- R2: An accepted request begins with three writes, in this order: data 8'hAA to address 15'h5555, then 8'h55 to 15'h2AAA, then 8'hA0 to 15'h5555.
- R3: After the unlock, exactly `reqCount` writes follow. Write i (from 0) sends buffer entry i (`bufAddr` = i) to address {`reqPage`, (`reqOffset` + i) mod 64}. Page bits 14..6 therefore stay the same throughout the load.
- R4: Let P be `reqPhase`, with 0 taken as 1. In every write, `weN` is low for exactly P cycles and high for at least P cycles between writes. Address and data are steady for at least P cycles before `weN` falls and do not change while it is low. `oeN` is high whenever `weN` is low, and the data bus is never driven while `oeN` is low.
- R5: With `reqToggle`=0, the engine polls by reading the last address written, holding `oeN` low for at least P cycles per read. It finishes on the first read whose bit 7 equals bit 7 of the last byte written.
- R6: With `reqToggle`=1, the engine polls the same address and finishes once two consecutive reads return equal bit 6.
- R7: If no completion is seen within MAX_WAIT polling cycles, `timeoutErr` pulses for one cycle, `done` stays 0 and the engine returns to idle.
- R8: A start request with `reqCount` of 0 or above 64 raises `rejectErr` for one cycle, starting on the cycle after the request. `busy` stays 0 and no strobe moves.
- R9: `busy` rises on the cycle after an accepted start and falls on the cycle after a one-cycle `done` or `timeoutErr` pulse, which comes no later than a few poll periods after the device completes.
- R10: On the cycle after `done`, `ceN` is back at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, sampled while idle |
| reqPage | input | 9 | Page number (address bits 14..6) |
| reqOffset | input | 6 | Page offset of the first data byte |
| reqCount | input | 7 | Number of data bytes, 1 to 64 |
| reqPhase | input | 8 | Clock cycles per bus phase (0 acts as 1) |
| reqToggle | input | 1 | 1 selects bit-6 toggle polling |
| bufAddr | output | 6 | Index of the buffer entry being written |
| bufData | input | 8 | Buffer entry at `bufAddr` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: programming completed |
| timeoutErr | output | 1 | One-cycle pulse: completion not seen in budget |
| rejectErr | output | 1 | One-cycle pulse: byte count refused |
| ceN | output | 1 | Chip enable, active low |
| oeN | output | 1 | Output enable, active low |
| weN | output | 1 | Write enable, active low |
| memAddr | output | 15 | Memory address bus |
| memDataOut | output | 8 | Data driven toward memory |
| memDataOe | output | 1 | Data drive enable for the pad |
| memDataIn | input | 8 | Data returned by memory |

## Verification
All strobes come from registers, so each bus event lags the controller state by one cycle. `rejectErr` and `busy` are due one cycle after the start edge. `done` is due within about six phase lengths after the device model finishes, and `ceN` returns high one cycle after `done`. The bench drives on falling edges and samples on the falling edge that follows the cycle in which each result is due. Bus timing is measured in whole cycles by a device model that logs every write strobe and every read strobe. That model checks each measured phase against P and times its own programming delay, so early or late completion reports can be bounded from both sides.

// File: rtl/eeprog_pkg.sv
package eeprog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSET, ST_WLOW, ST_WHIGH, ST_PREAD, ST_PGAP, ST_FIN, ST_TOUT
  } progState_t;

  typedef struct packed {
    logic latchReq;
    logic phaseClr;
    logic stepInc;
    logic busOn;
    logic weLow;
    logic oeLow;
    logic driveData;
    logic sampleRead;
    logic waitClr;
    logic waitRun;
  } ctrlStrobes_t;

endpackage

// File: rtl/eeprog_datapath.sv
module eeprog_datapath
  import eeprog_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int PHASE_W    = 8,
  parameter int MAX_WAIT   = 2_100_000,
  parameter logic [ADDR_W-1:0] CMD_ADDR_A = 'h5555,
  parameter logic [ADDR_W-1:0] CMD_ADDR_B = 'h2AAA,
  parameter logic [DATA_W-1:0] CMD_DATA_1 = 'hAA,
  parameter logic [DATA_W-1:0] CMD_DATA_2 = 'h55,
  parameter logic [DATA_W-1:0] CMD_DATA_3 = 'hA0,
  localparam int OFS_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFS_W,
  localparam int CNT_W  = $clog2(PAGE_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       str,
  input  logic [PAGE_W-1:0]  reqPage,
  input  logic [OFS_W-1:0]   reqOffset,
  input  logic [CNT_W-1:0]   reqCount,
  input  logic [PHASE_W-1:0] reqPhase,
  input  logic               reqToggle,
  output logic [OFS_W-1:0]   bufAddr,
  input  logic [DATA_W-1:0]  bufData,
  input  logic [DATA_W-1:0]  memDataIn,
  output logic               ceN,
  output logic               oeN,
  output logic               weN,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memDataOut,
  output logic               memDataOe,
  output logic               phaseEnd,
  output logic               lastStep,
  output logic               pollMatch,
  output logic               waitExpired
);

  localparam int STEP_W = $clog2(PAGE_BYTES + 3);
  localparam int WAIT_W = $clog2(MAX_WAIT + 1);
  localparam logic [PHASE_W:0]  PH_ONE    = 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(MAX_WAIT - 1);

  logic [PAGE_W-1:0]  pageR;
  logic [OFS_W-1:0]   offR;
  logic [CNT_W-1:0]   cntR;
  logic [PHASE_W-1:0] phaseR;
  logic               toggleR;
  logic [STEP_W-1:0]  stepIdx;
  logic [PHASE_W-1:0] phaseCnt;
  logic [WAIT_W-1:0]  waitCnt;
  logic [DATA_W-1:0]  curRead;
  logic               prevBit6;
  logic [1:0]         readCnt;

  logic [PHASE_W-1:0] effPhase;
  logic [STEP_W-1:0]  dataIdx;
  logic [ADDR_W-1:0]  stepAddr;
  logic [DATA_W-1:0]  stepData;

  assign effPhase = (phaseR == '0) ? PHASE_W'(1) : phaseR;
  assign phaseEnd = ({1'b0, phaseCnt} + PH_ONE) >= {1'b0, effPhase};
  assign dataIdx  = stepIdx - STEP_W'(3);
  assign bufAddr  = dataIdx[OFS_W-1:0];
  assign lastStep = stepIdx == (STEP_W'(cntR) + STEP_W'(2));
  assign waitExpired = waitCnt >= WAIT_LAST;

  always_comb begin
    case (stepIdx)
      STEP_W'(0): begin stepAddr = CMD_ADDR_A; stepData = CMD_DATA_1; end
      STEP_W'(1): begin stepAddr = CMD_ADDR_B; stepData = CMD_DATA_2; end
      STEP_W'(2): begin stepAddr = CMD_ADDR_A; stepData = CMD_DATA_3; end
      default: begin
        stepAddr = {pageR, offR + dataIdx[OFS_W-1:0]};
        stepData = bufData;
      end
    endcase
  end

  // Completion test: bit 7 against the written byte, or bit 6 steady twice.
  always_comb begin
    if (toggleR) pollMatch = (readCnt == 2'd2) && (curRead[6] == prevBit6);
    else         pollMatch = (readCnt != 2'd0) && (curRead[DATA_W-1] == memDataOut[DATA_W-1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageR <= '0; offR <= '0; cntR <= '0; phaseR <= '0; toggleR <= 1'b0;
      stepIdx <= '0; phaseCnt <= '0; waitCnt <= '0;
      curRead <= '0; prevBit6 <= 1'b0; readCnt <= 2'd0;
    end else begin
      if (str.latchReq) begin
        pageR <= reqPage; offR <= reqOffset; cntR <= reqCount;
        phaseR <= reqPhase; toggleR <= reqToggle;
        stepIdx <= '0; readCnt <= 2'd0;
      end else if (str.stepInc) begin
        stepIdx <= stepIdx + STEP_W'(1);
      end
      phaseCnt <= str.phaseClr ? '0 : phaseCnt + PHASE_W'(1);
      if (str.waitClr || str.latchReq) waitCnt <= '0;
      else if (str.waitRun && !waitExpired) waitCnt <= waitCnt + WAIT_W'(1);
      if (str.sampleRead) begin
        curRead  <= memDataIn;
        prevBit6 <= curRead[6];
        if (readCnt != 2'd2) readCnt <= readCnt + 2'd1;
      end
    end
  end

  // Registered pad-side strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceN <= 1'b1; oeN <= 1'b1; weN <= 1'b1; memDataOe <= 1'b0;
      memAddr <= '0; memDataOut <= '0;
    end else begin
      ceN       <= !str.busOn;
      oeN       <= !str.oeLow;
      weN       <= !str.weLow;
      memDataOe <= str.driveData;
      if (str.driveData) begin
        memAddr    <= stepAddr;
        memDataOut <= stepData;
      end
    end
  end

  // R4
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> oeN);
  // R4
  read_undriven_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> !memDataOe);
  // R4
  strobe_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> ($stable(memAddr) && $stable(memDataOut)));
  // R3
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && stepIdx >= STEP_W'(3)) |-> (memAddr[ADDR_W-1:OFS_W] == pageR));

endmodule

// File: rtl/eeprog_ctrl.sv
module eeprog_ctrl
  import eeprog_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  localparam int CNT_W = $clog2(PAGE_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             phaseEnd,
  input  logic             lastStep,
  input  logic             pollMatch,
  input  logic             waitExpired,
  output ctrlStrobes_t     str,
  output logic             busy,
  output logic             done,
  output logic             timeoutErr,
  output logic             rejectErr
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(PAGE_BYTES);

  progState_t state, nxt;
  logic       gapFirst;
  logic       countOk;

  assign countOk = (reqCount != '0) && (reqCount <= MAX_CNT);

  always_comb begin
    nxt = state;
    str = '0;
    case (state)
      ST_IDLE: if (startReq && countOk) begin
        str.latchReq = 1'b1; str.phaseClr = 1'b1; nxt = ST_WSET;
      end
      ST_WSET: begin
        str.busOn = 1'b1; str.driveData = 1'b1;
        if (phaseEnd) begin str.phaseClr = 1'b1; nxt = ST_WLOW; end
      end
      ST_WLOW: begin
        str.busOn = 1'b1; str.driveData = 1'b1; str.weLow = 1'b1;
        if (phaseEnd) begin str.phaseClr = 1'b1; nxt = ST_WHIGH; end
      end
      ST_WHIGH: begin
        str.busOn = 1'b1; str.driveData = 1'b1;
        if (phaseEnd) begin
          str.phaseClr = 1'b1;
          if (lastStep) begin str.waitClr = 1'b1; nxt = ST_PREAD; end
          else begin str.stepInc = 1'b1; nxt = ST_WSET; end
        end
      end
      ST_PREAD: begin
        str.busOn = 1'b1; str.oeLow = 1'b1; str.waitRun = 1'b1;
        if (waitExpired) nxt = ST_TOUT;
        else if (phaseEnd) begin str.phaseClr = 1'b1; nxt = ST_PGAP; end
      end
      ST_PGAP: begin
        str.busOn = 1'b1; str.waitRun = 1'b1; str.sampleRead = gapFirst;
        if (phaseEnd && !gapFirst && pollMatch) nxt = ST_FIN;
        else if (waitExpired) nxt = ST_TOUT;
        else if (phaseEnd && !gapFirst) begin str.phaseClr = 1'b1; nxt = ST_PREAD; end
      end
      ST_FIN:  nxt = ST_IDLE;
      ST_TOUT: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; gapFirst <= 1'b0; rejectErr <= 1'b0;
    end else begin
      state     <= nxt;
      gapFirst  <= (state == ST_PREAD) && (nxt == ST_PGAP);
      rejectErr <= (state == ST_IDLE) && startReq && !countOk;
    end
  end

  assign busy       = state != ST_IDLE;
  assign done       = state == ST_FIN;
  assign timeoutErr = state == ST_TOUT;

  // R8
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    rejectErr |-> !busy);
  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || timeoutErr) |=> !busy);
  // R7
  tout_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> $past(waitExpired));

endmodule

// File: rtl/eeprog_top.sv
module eeprog_top
  import eeprog_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 64,
  parameter int PHASE_W    = 8,
  parameter int MAX_WAIT   = 2_100_000,
  localparam int OFS_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFS_W,
  localparam int CNT_W  = $clog2(PAGE_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [PAGE_W-1:0]  reqPage,
  input  logic [OFS_W-1:0]   reqOffset,
  input  logic [CNT_W-1:0]   reqCount,
  input  logic [PHASE_W-1:0] reqPhase,
  input  logic               reqToggle,
  output logic [OFS_W-1:0]   bufAddr,
  input  logic [DATA_W-1:0]  bufData,
  output logic               busy,
  output logic               done,
  output logic               timeoutErr,
  output logic               rejectErr,
  output logic               ceN,
  output logic               oeN,
  output logic               weN,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memDataOut,
  output logic               memDataOe,
  input  logic [DATA_W-1:0]  memDataIn
);

  ctrlStrobes_t str;
  logic phaseEnd, lastStep, pollMatch, waitExpired;

  eeprog_ctrl #(.PAGE_BYTES(PAGE_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .reqCount(reqCount),
    .phaseEnd(phaseEnd), .lastStep(lastStep), .pollMatch(pollMatch),
    .waitExpired(waitExpired), .str(str), .busy(busy), .done(done),
    .timeoutErr(timeoutErr), .rejectErr(rejectErr)
  );

  eeprog_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
    .PHASE_W(PHASE_W), .MAX_WAIT(MAX_WAIT)
  ) uPath (
    .clk(clk), .rstN(rstN), .str(str), .reqPage(reqPage),
    .reqOffset(reqOffset), .reqCount(reqCount), .reqPhase(reqPhase),
    .reqToggle(reqToggle), .bufAddr(bufAddr), .bufData(bufData),
    .memDataIn(memDataIn), .ceN(ceN), .oeN(oeN), .weN(weN),
    .memAddr(memAddr), .memDataOut(memDataOut), .memDataOe(memDataOe),
    .phaseEnd(phaseEnd), .lastStep(lastStep), .pollMatch(pollMatch),
    .waitExpired(waitExpired)
  );

endmodule

// File: tb/tb_eeprog_top.sv
`timescale 1ns/1ps
module tb_eeprog_top;

  localparam int MAXW = 2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic startReq = 1'b0;
  logic [8:0] reqPage = '0;
  logic [5:0] reqOffset = '0;
  logic [6:0] reqCount = '0;
  logic [7:0] reqPhase = '0;
  logic reqToggle = 1'b0;
  logic [5:0] bufAddr;
  logic [7:0] bufData;
  logic busy, done, timeoutErr, rejectErr, ceN, oeN, weN, memDataOe;
  logic [14:0] memAddr;
  logic [7:0] memDataOut, memDataIn;

  eeprog_top #(.MAX_WAIT(MAXW)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .reqPage(reqPage),
    .reqOffset(reqOffset), .reqCount(reqCount), .reqPhase(reqPhase),
    .reqToggle(reqToggle), .bufAddr(bufAddr), .bufData(bufData),
    .busy(busy), .done(done), .timeoutErr(timeoutErr), .rejectErr(rejectErr),
    .ceN(ceN), .oeN(oeN), .weN(weN), .memAddr(memAddr),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  logic [7:0] bufMem [0:63];
  always_comb bufData = bufMem[bufAddr];

  // ---------------- device model and bus monitor ----------------
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic logClr = 1'b0;
  int progLen = 100;
  logic [14:0] wAddr [0:79];
  logic [7:0]  wData [0:79];
  int wCount, progRemain, doneCyc, lastRiseCyc;
  int lowRun, highRun, oeRun, stableCnt;
  int minLow, maxLow, minHigh, minSetup, minOeLow;
  logic progActive, tog, ovl, drvBad, pollBad, ceBad;
  logic prevWeN, prevOeN;
  logic [14:0] prevAddr, lastAddr;
  logic [7:0] prevData, lastData;

  always_comb memDataIn = progActive ? {~lastData[7], tog, lastData[5:0]} : lastData;

  always @(posedge clk) begin
    prevWeN <= weN; prevOeN <= oeN; prevAddr <= memAddr; prevData <= memDataOut;
    if (memAddr != prevAddr || memDataOut != prevData) stableCnt <= 1;
    else if (stableCnt < 100000) stableCnt <= stableCnt + 1;
    if (!rstN || logClr) begin
      wCount <= 0; progActive <= 1'b0; progRemain <= 0; tog <= 1'b0;
      ovl <= 1'b0; drvBad <= 1'b0; pollBad <= 1'b0; ceBad <= 1'b0;
      minLow <= 9999; maxLow <= 0; minHigh <= 9999; minSetup <= 9999; minOeLow <= 9999;
      lowRun <= 0; highRun <= 0; oeRun <= 0; doneCyc <= 0; lastRiseCyc <= 0;
      lastAddr <= '0; lastData <= '0;
      if (!rstN) begin prevWeN <= 1'b1; prevOeN <= 1'b1; end
    end else begin
      if (!weN && !oeN) ovl <= 1'b1;
      if (!oeN && memDataOe) drvBad <= 1'b1;
      if (!oeN && memAddr != lastAddr) pollBad <= 1'b1;
      if ((!weN || !oeN) && ceN) ceBad <= 1'b1;
      if (progActive) begin
        if (progRemain == 0) begin progActive <= 1'b0; doneCyc <= cyc; end
        else progRemain <= progRemain - 1;
      end
      if (prevOeN && !oeN && progActive) tog <= ~tog;
      if (!oeN) oeRun <= oeRun + 1;
      if (oeN && !prevOeN) begin
        if (oeRun < minOeLow) minOeLow <= oeRun;
        oeRun <= 0;
      end
      if (!weN) lowRun <= lowRun + 1;
      if (weN) highRun <= highRun + 1;
      if (!weN && prevWeN) begin
        if (wCount > 0 && highRun < minHigh) minHigh <= highRun;
        if (stableCnt < minSetup) minSetup <= stableCnt;
        highRun <= 0;
      end
      if (weN && !prevWeN) begin
        if (lowRun < minLow) minLow <= lowRun;
        if (lowRun > maxLow) maxLow <= lowRun;
        lowRun <= 0;
        if (wCount < 80) begin wAddr[wCount] <= memAddr; wData[wCount] <= memDataOut; end
        wCount <= wCount + 1;
        lastAddr <= memAddr; lastData <= memDataOut;
        progActive <= 1'b1; progRemain <= progLen; lastRiseCyc <= cyc;
      end
    end
  end

  // ---------------- checking ----------------
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int effPh(input int ph);
    return (ph == 0) ? 1 : ph;
  endfunction

  function automatic logic [14:0] expAddr(input int pg, input int ofs, input int i);
    return {9'(pg), 6'((ofs + i) % 64)};
  endfunction

  task automatic clearModel();
    @(negedge clk) logClr = 1'b1;
    @(negedge clk) logClr = 1'b0;
  endtask

  task automatic tryReject(input int cnt);
    clearModel();
    reqCount = 7'(cnt);
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    chk(rejectErr == 1'b1, "R8", "rejectErr after bad count", rejectErr, 1);
    chk(busy == 1'b0, "R8", "busy after reject", busy, 0);
    @(negedge clk);
    chk(rejectErr == 1'b0, "R8", "rejectErr one cycle", rejectErr, 0);
    repeat (20) @(negedge clk);
    chk(wCount == 0 && ceN && oeN && weN && !busy, "R8", "bus activity after reject",
        wCount, 0);
  endtask

  task automatic runOp(input int cnt, input int ofs, input int pg, input int ph,
                       input bit tgl, input int plen, input bit expTout);
    int guard;
    int p;
    string ptag;
    p = effPh(ph);
    ptag = tgl ? "R6" : "R5";
    for (int i = 0; i < 64; i++) bufMem[i] = 8'($urandom);
    progLen = plen;
    clearModel();
    reqPage = 9'(pg); reqOffset = 6'(ofs); reqCount = 7'(cnt);
    reqPhase = 8'(ph); reqToggle = tgl;
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    guard = 0;
    while (!done && !timeoutErr && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    if (expTout) begin
      chk(timeoutErr && !done, "R7", "timeout pulse without done", timeoutErr, 1);
      chk((cyc - lastRiseCyc) >= MAXW && (cyc - lastRiseCyc) <= MAXW + 3*p + 10,
          "R7", "timeout latency from last write", cyc - lastRiseCyc, MAXW + p);
    end else begin
      chk(done && !timeoutErr, ptag, "done pulse", done, 1);
      chk(!progActive && doneCyc > 0, ptag, "done only after device finished", progActive, 0);
      chk((cyc - doneCyc) <= 6*p + 10, ptag, "done latency after device finish",
          cyc - doneCyc, 6*p + 10);
    end
    chk(wCount == cnt + 3, "R3", "write strobe count", wCount, cnt + 3);
    chk(wAddr[0] == 15'h5555 && wData[0] == 8'hAA, "R2", "unlock write 1", wAddr[0], 15'h5555);
    chk(wAddr[1] == 15'h2AAA && wData[1] == 8'h55, "R2", "unlock write 2", wAddr[1], 15'h2AAA);
    chk(wAddr[2] == 15'h5555 && wData[2] == 8'hA0, "R2", "unlock write 3", wData[2], 8'hA0);
    for (int i = 0; i < cnt; i++) begin
      if (wAddr[i+3] != expAddr(pg, ofs, i))
        chk(1'b0, "R3", "data write address", wAddr[i+3], expAddr(pg, ofs, i));
      if (wData[i+3] != bufMem[i])
        chk(1'b0, "R3", "data write value", wData[i+3], bufMem[i]);
    end
    chk(minLow == p && maxLow == p, "R4", "write low width", minLow, p);
    chk(minHigh >= p, "R4", "write high gap", minHigh, p);
    chk(minSetup >= p, "R4", "address/data setup", minSetup, p);
    chk(!ovl && !drvBad && !ceBad, "R4", "strobe overlap or drive during read", ovl, 0);
    chk(!pollBad, ptag, "poll address equals last written", pollBad, 0);
    chk(minOeLow >= p, ptag, "read strobe width", minOeLow, p);
    @(negedge clk);
    chk(!busy && !done && !timeoutErr, "R9", "idle after finish", busy, 0);
    chk(ceN == 1'b1, "R10", "chip enable released", ceN, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) bufMem[i] = '0;
    repeat (4) @(negedge clk);
    chk(ceN && oeN && weN && !memDataOe, "R1", "bus idle in reset", {ceN, oeN, weN}, 7);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !timeoutErr && !rejectErr, "R1", "flags after reset", busy, 0);
    chk(ceN && oeN && weN && !memDataOe, "R1", "bus idle after reset", memDataOe, 0);

    tryReject(0);
    tryReject(65);
    tryReject(127);

    runOp(1, 0, 0, 1, 1'b0, 60, 1'b0);
    runOp(64, 17, 9'h1FF, 2, 1'b1, 150, 1'b0);
    runOp(5, 62, 3, 0, 1'b0, 80, 1'b0);
    runOp(3, 7, 44, 3, 1'b1, 90, 1'b0);
    runOp(2, 5, 100, 1, 1'b0, 60000, 1'b1);
    runOp(2, 5, 101, 2, 1'b1, 60000, 1'b1);
    for (int k = 0; k < 12; k++)
      runOp($urandom_range(1, 64), $urandom_range(0, 63), $urandom_range(0, 511),
            $urandom_range(0, 4), 1'($urandom_range(0, 1)), $urandom_range(50, 400), 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R9: run did not end actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule